// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This block collects the event flags of a serial-bus master into one sixteen-bit status word. It combines them with a six-bit enable mask to drive a single level-sensitive interrupt line, and with a two-bit DMA control word to drive a receive and a transmit DMA request. The transfer engine raises flags with one-cycle set pulses. Software reads and writes the unit through simple read and write strobes that carry a three-bit register select and sixteen-bit data.

Software can clear some flags by writing ones to the status word. The two data-ready flags are cleared only by the data path, or by a vector read. Software can also read a vector: the number of the most urgent pending enabled event, with the lowest bit number being the most urgent. That read acknowledges the event. A build-time parameter picks between an older variant, which has a five-bit mask and no forcing test hook, and a newer variant, which has a six-bit mask and a self-test write that raises the low six flags.

The unit has no streaming data, so every pin is a plain level or strobe. A read returns its data combinationally in the cycle `rd_en` is high. Any side effect of that read, and any write, takes effect at the next rising clock edge.

Top module: `irq_status_unit`

## Requirements
- R1: `irq` is high exactly when some stored status bit 5..0 is set and its enable-mask bit is also set; with the mask at zero, `irq` stays low whatever the status holds.
- R2: A pulse on `evt_set[k]`, for any k other than 12, sets status bit k at the next clock edge. It stays set until a clear reaches it. The bit positions are: 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 10 transmit underflow, 11 receive overrun, 15 single byte.
- R3: A read of select 2 (vector) returns the index of the lowest set bit of (status AND mask), plus one. At the next edge it clears that one status bit.
- R4: A vector read with nothing pending and enabled returns 0 and leaves the status unchanged.
- R5: A write to select 0 (status) clears only the status bits set in (wdata AND 0x0027). Bits 3 and 4 (receive and transmit ready) are never cleared by it.
- R6: When a set pulse and any clear (a status write or a vector read) hit the same bit in the same cycle, the bit ends up set.
- R7: `dma_rx_req` equals status bit 3 while DMA-control bit 15 is set, and is low otherwise. `dma_tx_req` equals status bit 4 while DMA-control bit 7 is set, and is low otherwise.
- R8: A write to select 3 (DMA control) stores only bits 15 and 7 (mask 0x8080). Bit 15 set clears enable bit 3, and bit 7 set clears enable bit 4. A read of select 3 returns the stored word.
- R9: A write to select 1 (enable) keeps wdata AND 0x3F in the newer variant (`NEWER_VARIANT`=1) and wdata AND 0x1F in the older one. A read of select 1 returns the stored mask.
- R10: In the newer variant, a write to select 4 (self-test) with bit 11 set forces status bits 5..0 to one. In the older variant that write has no effect on the status.
- R11: A read of select 0 returns the stored status with bit 12 replaced by the live `bus_busy` input. Bit 12 is never stored.
- R12: A synchronous reset clears the status, the mask and the DMA control word, so `irq` and both DMA requests go low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register select: 0 status, 1 enable, 2 vector, 3 DMA control, 4 self-test |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid while rd_en is high, zero otherwise |
| evt_set | input | 16 | One-cycle set pulses, one per status bit |
| bus_busy | input | 1 | Live bus-busy level shown in status bit 12 |
| irq | output | 1 | Interrupt request |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
The assertions check on every cycle that a set pulse always sticks, so set wins over any clear. They also check that the data-ready flags survive status writes, that a vector read clears at most one bit, that a DMA enable removes its ready-interrupt enable, that the older variant never holds mask bit 5, and that the interrupt and DMA requests never rise without their enables. Only the bench scenarios can show the values: the priority order of vector codes, the zero code when nothing is pending, the exact results of masked clears and of forcing in each variant, the live busy bit, and the reset values of the readback.

// File: rtl/ivu_pkg.sv
package ivu_pkg;
  localparam int ST_W   = 16;
  localparam int EN_W   = 6;
  localparam int SEL_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_STATUS = 3'd0,
    SEL_ENABLE = 3'd1,
    SEL_VECTOR = 3'd2,
    SEL_DMA    = 3'd3,
    SEL_TEST   = 3'd4
  } reg_sel_e;

  localparam int B_RRDY = 3;
  localparam int B_XRDY = 4;
  localparam int B_BUSY = 12;

  localparam logic [ST_W-1:0] SW_CLR_MASK = 16'h0027;
  localparam logic [ST_W-1:0] DMA_KEEP    = 16'h8080;
  localparam int DMA_RX_BIT  = 15;
  localparam int DMA_TX_BIT  = 7;
  localparam int FORCE_BIT   = 11;
endpackage

// File: rtl/ivu_decode.sv
module ivu_decode
  import ivu_pkg::*;
(
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [SEL_W-1:0] addr,
  output logic             wr_stat,
  output logic             wr_mask,
  output logic             wr_dma,
  output logic             wr_test,
  output logic             rd_vec
);
  always_comb begin
    wr_stat = wr_en && (addr == SEL_STATUS);
    wr_mask = wr_en && (addr == SEL_ENABLE);
    wr_dma  = wr_en && (addr == SEL_DMA);
    wr_test = wr_en && (addr == SEL_TEST);
    rd_vec  = rd_en && (addr == SEL_VECTOR);
  end
endmodule

// File: rtl/ivu_ctrl.sv
module ivu_ctrl
  import ivu_pkg::*;
#(
  parameter bit NEWER_VARIANT = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_mask,
  input  logic            wr_dma,
  input  logic [ST_W-1:0] wdata,
  output logic [EN_W-1:0] mask_q,
  output logic [ST_W-1:0] dma_q
);
  localparam logic [EN_W-1:0] MASK_KEEP = NEWER_VARIANT ? 6'h3F : 6'h1F;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      dma_q  <= '0;
    end else if (wr_mask) begin
      mask_q <= wdata[EN_W-1:0] & MASK_KEEP;
    end else if (wr_dma) begin
      dma_q <= wdata & DMA_KEEP;
      if (wdata[DMA_RX_BIT]) mask_q[B_RRDY] <= 1'b0;
      if (wdata[DMA_TX_BIT]) mask_q[B_XRDY] <= 1'b0;
    end
  end

  p_rx_dma_drops_ie_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_dma && wdata[DMA_RX_BIT]) |=> !mask_q[B_RRDY])
    else $error("rx dma enable left ready-receive enable on");
  p_tx_dma_drops_ie_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_dma && wdata[DMA_TX_BIT]) |=> !mask_q[B_XRDY])
    else $error("tx dma enable left ready-transmit enable on");

  generate
    if (!NEWER_VARIANT) begin : g_old_chk
      p_old_mask_width_r9: assert property (@(posedge clk) disable iff (rst)
        !mask_q[EN_W-1])
        else $error("older variant holds mask bit 5");
    end
  endgenerate
endmodule

// File: rtl/ivu_vector.sv
module ivu_vector
  import ivu_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_vec,
  input  logic [ST_W-1:0] stat_q,
  input  logic [EN_W-1:0] mask_q,
  output logic [ST_W-1:0] vec_code,
  output logic [ST_W-1:0] vec_clr
);
  localparam int IDX_W = $clog2(EN_W + 1);

  logic [EN_W-1:0]  pend;
  logic [IDX_W-1:0] idx;
  logic             hit;

  always_comb begin
    pend = stat_q[EN_W-1:0] & mask_q;
    idx  = '0;
    hit  = 1'b0;
    for (int i = EN_W - 1; i >= 0; i--) begin
      if (pend[i]) begin
        idx = IDX_W'(i);
        hit = 1'b1;
      end
    end
    vec_code = hit ? ST_W'(idx) + ST_W'(1) : '0;
    vec_clr  = '0;
    if (hit && rd_vec) vec_clr[idx] = 1'b1;
  end

  p_one_clear_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(vec_clr))
    else $error("vector read clears more than one flag");
  p_code_range_r3: assert property (@(posedge clk) disable iff (rst)
    rd_vec |-> (vec_code <= ST_W'(EN_W)))
    else $error("vector code out of range");
  p_idle_no_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_vec && (pend == '0)) |-> (vec_clr == '0))
    else $error("empty vector read clears a flag");
endmodule

// File: rtl/ivu_status.sv
module ivu_status
  import ivu_pkg::*;
#(
  parameter bit NEWER_VARIANT = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ST_W-1:0] evt_set,
  input  logic            wr_stat,
  input  logic            wr_test,
  input  logic [ST_W-1:0] wdata,
  input  logic [ST_W-1:0] vec_clr,
  output logic [ST_W-1:0] stat_q
);
  localparam logic [ST_W-1:0] STORE_MASK = ~(ST_W'(1) << B_BUSY);

  logic            force_low;
  logic [ST_W-1:0] stat_d;

  generate
    if (NEWER_VARIANT) begin : g_force
      assign force_low = wr_test && wdata[FORCE_BIT];
    end else begin : g_noforce
      assign force_low = 1'b0;
    end
  endgenerate

  always_comb begin
    stat_d = stat_q;
    if (wr_stat) stat_d = stat_d & ~(wdata & SW_CLR_MASK);
    stat_d = stat_d & ~vec_clr;
    if (force_low) stat_d[EN_W-1:0] = '1;
    stat_d = (stat_d | evt_set) & STORE_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_d;
  end

  generate
    for (genvar b = 0; b < ST_W; b++) begin : g_chk
      if (b != B_BUSY) begin : g_bit
        p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
          evt_set[b] |=> stat_q[b])
          else $error("set pulse lost on bit %0d", b);
      end
    end
  endgenerate

  p_rrdy_sw_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (stat_q[B_RRDY] && !vec_clr[B_RRDY]) |=> stat_q[B_RRDY])
    else $error("receive-ready cleared by software write");
  p_xrdy_sw_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (stat_q[B_XRDY] && !vec_clr[B_XRDY]) |=> stat_q[B_XRDY])
    else $error("transmit-ready cleared by software write");
  p_busy_unstored_r11: assert property (@(posedge clk) disable iff (rst)
    !stat_q[B_BUSY])
    else $error("busy bit stored");
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import ivu_pkg::*;
#(
  parameter bit NEWER_VARIANT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [SEL_W-1:0] addr,
  input  logic [ST_W-1:0]  wdata,
  output logic [ST_W-1:0]  rdata,
  input  logic [ST_W-1:0]  evt_set,
  input  logic             bus_busy,
  output logic             irq,
  output logic             dma_rx_req,
  output logic             dma_tx_req
);
  logic            wr_stat, wr_mask, wr_dma, wr_test, rd_vec;
  logic [EN_W-1:0] mask_q;
  logic [ST_W-1:0] dma_q, stat_q, vec_code, vec_clr;

  ivu_decode u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_stat(wr_stat), .wr_mask(wr_mask), .wr_dma(wr_dma),
    .wr_test(wr_test), .rd_vec(rd_vec)
  );

  ivu_ctrl #(.NEWER_VARIANT(NEWER_VARIANT)) u_ctrl (
    .clk(clk), .rst(rst), .wr_mask(wr_mask), .wr_dma(wr_dma),
    .wdata(wdata), .mask_q(mask_q), .dma_q(dma_q)
  );

  ivu_vector u_vec (
    .clk(clk), .rst(rst), .rd_vec(rd_vec), .stat_q(stat_q),
    .mask_q(mask_q), .vec_code(vec_code), .vec_clr(vec_clr)
  );

  ivu_status #(.NEWER_VARIANT(NEWER_VARIANT)) u_stat (
    .clk(clk), .rst(rst), .evt_set(evt_set), .wr_stat(wr_stat),
    .wr_test(wr_test), .wdata(wdata), .vec_clr(vec_clr), .stat_q(stat_q)
  );

  assign irq        = |(stat_q[EN_W-1:0] & mask_q);
  assign dma_rx_req = dma_q[DMA_RX_BIT] & stat_q[B_RRDY];
  assign dma_tx_req = dma_q[DMA_TX_BIT] & stat_q[B_XRDY];

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (addr)
        SEL_STATUS: begin
          rdata = stat_q;
          rdata[B_BUSY] = bus_busy;
        end
        SEL_ENABLE: rdata = ST_W'(mask_q);
        SEL_VECTOR: rdata = vec_code;
        SEL_DMA:    rdata = dma_q;
        default:    rdata = '0;
      endcase
    end
  end

  p_irq_needs_enable_r1: assert property (@(posedge clk) disable iff (rst)
    irq |-> (mask_q != '0))
    else $error("interrupt with empty mask");
  p_rx_req_needs_flag_r7: assert property (@(posedge clk) disable iff (rst)
    dma_rx_req |-> (stat_q[B_RRDY] && dma_q[DMA_RX_BIT]))
    else $error("rx request without ready flag");
  p_tx_req_needs_flag_r7: assert property (@(posedge clk) disable iff (rst)
    dma_tx_req |-> (stat_q[B_XRDY] && dma_q[DMA_TX_BIT]))
    else $error("tx request without ready flag");
endmodule

// File: tb/sim_irq_status_unit.sv
module sim_irq_status_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, bus_busy = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0, evt_set = '0;
  logic [15:0] rdata, rdata1;
  logic        irq, drx, dtx, irq1, drx1, dtx1;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  int          q_kind[$];
  logic [15:0] q_exp[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  irq_status_unit #(.NEWER_VARIANT(1'b1)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_set(evt_set), .bus_busy(bus_busy),
    .irq(irq), .dma_rx_req(drx), .dma_tx_req(dtx)
  );

  irq_status_unit #(.NEWER_VARIANT(1'b0)) u1 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata1), .evt_set(evt_set), .bus_busy(bus_busy),
    .irq(irq1), .dma_rx_req(drx1), .dma_tx_req(dtx1)
  );

  // kinds: 0 u0 rdata, 1 u0 irq, 2 u0 rx req, 3 u0 tx req, 4 u1 rdata
  task automatic push(input int k, input logic [15:0] e, input string t);
    q_kind.push_back(k);
    q_exp.push_back(e);
    q_tag.push_back(t);
  endtask

  always begin : monitor
    @(negedge clk);
    #2;
    while (q_kind.size() > 0) begin
      int k;
      logic [15:0] e, a;
      string t;
      k = q_kind.pop_front();
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      case (k)
        0: a = rdata;
        1: a = {15'd0, irq};
        2: a = {15'd0, drx};
        3: a = {15'd0, dtx};
        default: a = rdata1;
      endcase
      compared++;
      if (a !== e) begin
        mismatched++;
        $display("FAIL %s kind %0d actual %h expected %h", t, k, a, e);
      end
    end
  end

  task automatic rd(input logic [2:0] a, input logic [15:0] e0,
                    input logic [15:0] e1, input string t);
    addr = a; rd_en = 1'b1;
    push(0, e0, t);
    push(4, e1, t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] v);
    evt_set = v;
    @(negedge clk);
    evt_set = '0;
  endtask

  task automatic pins(input logic i, input logic rx, input logic tx, input string t);
    push(1, {15'd0, i}, t);
    push(2, {15'd0, rx}, t);
    push(3, {15'd0, tx}, t);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    rd(3'd0, 16'h0000, 16'h0000, "R12 status after reset");
    rd(3'd1, 16'h0000, 16'h0000, "R12 enable after reset");
    rd(3'd3, 16'h0000, 16'h0000, "R12 dma after reset");
    pins(1'b0, 1'b0, 1'b0, "R12 pins after reset");
    // R11 live busy
    bus_busy = 1'b1;
    rd(3'd0, 16'h1000, 16'h1000, "R11 busy shown live");
    bus_busy = 1'b0;
    rd(3'd0, 16'h0000, 16'h0000, "R11 busy follows input");
    // R2 set pulses, R9 mask width
    pulse(16'h000A);
    wr(3'd1, 16'hFFFF);
    rd(3'd0, 16'h000A, 16'h000A, "R2 flags set by pulses");
    rd(3'd1, 16'h003F, 16'h001F, "R9 mask width per variant");
    pins(1'b1, 1'b0, 1'b0, "R1 irq on pending enabled");
    // R3 R4 vector priority and ack
    rd(3'd2, 16'h0002, 16'h0002, "R3 vector lowest bit1");
    rd(3'd2, 16'h0004, 16'h0004, "R3 vector next bit3");
    rd(3'd2, 16'h0000, 16'h0000, "R4 vector empty");
    rd(3'd0, 16'h0000, 16'h0000, "R4 status unchanged after empty vector");
    pins(1'b0, 1'b0, 1'b0, "R1 irq low after acks");
    // R5 masked software clear
    pulse(16'h041E);
    wr(3'd0, 16'hFFFF);
    rd(3'd0, 16'h0418, 16'h0418, "R5 clear keeps ready and high bits");
    // R8 R7 DMA control
    wr(3'd3, 16'hFFFF);
    rd(3'd3, 16'h8080, 16'h8080, "R8 dma keeps 0x8080");
    rd(3'd1, 16'h0027, 16'h0007, "R8 dma clears ready enables");
    pins(1'b0, 1'b1, 1'b1, "R7 dma requests follow ready flags");
    wr(3'd3, 16'h0080);
    pins(1'b0, 1'b0, 1'b1, "R7 rx request off without enable");
    wr(3'd3, 16'h0000);
    pins(1'b0, 1'b0, 1'b0, "R7 both requests off");
    // R6 set wins over clear
    evt_set = 16'h0004; addr = 3'd0; wdata = 16'h0004; wr_en = 1'b1;
    @(negedge clk);
    evt_set = '0; wr_en = 1'b0;
    rd(3'd0, 16'h041C, 16'h041C, "R6 set beats status write");
    evt_set = 16'h0004;
    rd(3'd2, 16'h0003, 16'h0003, "R6 vector code bit2");
    evt_set = '0;
    rd(3'd0, 16'h041C, 16'h041C, "R6 set beats vector clear");
    // R10 self-test force
    wr(3'd4, 16'h0800);
    rd(3'd0, 16'h043F, 16'h041C, "R10 force only in newer variant");
    // R1 mask gating
    wr(3'd1, 16'h0000);
    pins(1'b0, 1'b0, 1'b0, "R1 irq low with zero mask");
    wr(3'd1, 16'h0002);
    pins(1'b1, 1'b0, 1'b0, "R1 irq high with bit1 enabled");
    // R12 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd(3'd0, 16'h0000, 16'h0000, "R12 status cleared by reset");
    rd(3'd1, 16'h0000, 16'h0000, "R12 mask cleared by reset");
    pins(1'b0, 1'b0, 1'b0, "R12 pins low after reset");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule